// File: doc/BRIEF.md
# Double-Buffered SPI Slave

This block is a byte-wide SPI slave for an on-chip peripheral bus. An external master drives the serial clock, the data line towards the slave and an active-low select. The slave returns data on its serial output and drives a separate output-enable for the pad. The slave has one internal shift register and two holding registers. The host can write the transmit holding register but cannot read it. The host can read the receive holding register but cannot write it. The host cannot reach the shifter at all. All three serial inputs pass through two-flop synchronisers, and edges are detected in the system clock domain, so the system clock must run at least four times faster than the serial clock.

The slave never starts a transfer. The host preloads a byte, and the shifter takes it when select falls or when a byte completes. If no byte is waiting, the shifter is filled with all ones. Each completed byte is copied into the receive holding register. A byte that arrives before the host has read the previous one overwrites it and sets a sticky overrun flag. An interrupt output combines the status flags under per-flag enables.

The bus is mode 0: data is sampled on the rising serial edge and the shifter moves right after it. Bit order is selectable per transfer.

Top module: `spi_slave_dbuf`

Register map (addr_i): 0 = data (write loads the transmit holding register, read returns the receive holding register), 1 = status, 2 = control.

## Requirements
- R1: After reset the status register reads 0x01. TX-empty (status bit 0) is set, and RX-full (bit 1), overrun (bit 2) and selected (bit 3) are clear. The control register reads 0x00, miso_oe_o and miso_o are 0, and irq_o is 0.
- R2: A write to address 0 stores the byte in the transmit holding register and clears TX-empty.
- R3: When the synchronised select falls, the shifter loads the holding byte if TX-empty is clear and then sets TX-empty. If TX-empty is already set, the shifter loads 0xFF. While select is low, status bit 3 reads 1.
- R4: With control bit 3 clear, bytes travel most-significant bit first. The MOSI bit is captured on each rising SCLK edge, and miso_o presents the next bit before the following rising edge.
- R5: After 8 rising edges within one select, the received byte is copied to the receive holding register and RX-full is set. A read of address 0 returns that byte and clears RX-full.
- R6: Each completed byte reloads the shifter at once, with the holding byte if one is waiting or with 0xFF if not. Bytes can therefore run back to back within one select.
- R7: If a byte completes while RX-full is set and no read happens in the same cycle, the new byte replaces the old one and overrun (status bit 2) is set. Overrun stays set until the host writes the status register with bit 2 set.
- R8: Raising select in the middle of a byte discards the partial bits and leaves RX-full unchanged. The next select starts counting bits from zero.
- R9: miso_oe_o is high only while the synchronised select is low. miso_o is 0 whenever miso_oe_o is low.
- R10: With control bit 3 set, both directions travel least-significant bit first.
- R11: irq_o is (TX-empty AND control bit 0) OR (RX-full AND control bit 1) OR (overrun AND control bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| cs_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for the serial data pad |
| addr_i | input | 2 | Host register address |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | DATA_W | Host write data |
| rd_en_i | input | 1 | Host read strobe; a read of address 0 has side effects |
| rd_data_o | output | DATA_W | Host read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit counter shows up on the master's side within one byte. The copy into the receive register then holds a shifted or partial value, and the load at the byte boundary lands in the middle of the next byte. A wrong TX-empty or RX-full flag appears in the next status read and on irq_o in the same cycle. It also changes which byte shifts out at the next select or byte boundary: the preloaded byte where 0xFF was due, or the reverse. A lost overrun flag shows on the first status read after a second unread byte.

// File: rtl/spi_slave_dbuf_pkg.sv
package spi_slave_dbuf_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned STAT_W = 7;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_CTRL = 2'd2
  } reg_addr_e;

  localparam int unsigned CTRL_IE_TX  = 0;
  localparam int unsigned CTRL_IE_RX  = 1;
  localparam int unsigned CTRL_IE_OVR = 2;
  localparam int unsigned CTRL_LSB    = 3;

  localparam int unsigned STAT_TXE = 0;
  localparam int unsigned STAT_RXF = 1;
  localparam int unsigned STAT_OVR = 2;
  localparam int unsigned STAT_SEL = 3;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= RST_VAL;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  input  logic              lsb_first_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_valid_i,
  output logic              load_o,
  output logic              rx_done_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              active_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              sclk_q, cs_q;
  logic [DATA_W-1:0] sh_q, sh_next, fill;
  logic [CNT_W-1:0]  cnt_q;
  logic              sel_fall, rise;

  assign active_o = ~cs_ni;
  assign sel_fall = cs_q & ~cs_ni;
  assign rise     = active_o & sclk_i & ~sclk_q;
  assign rx_done_o = rise & (cnt_q == LAST);
  assign load_o   = sel_fall | rx_done_o;
  assign fill     = tx_valid_i ? tx_byte_i : '1;
  assign sh_next  = lsb_first_i ? {mosi_i, sh_q[DATA_W-1:1]}
                                : {sh_q[DATA_W-2:0], mosi_i};
  assign rx_byte_o = sh_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      cnt_q  <= '0;
      sh_q   <= '1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (!active_o) begin
        cnt_q <= '0;
      end else if (sel_fall) begin
        sh_q  <= fill;
        cnt_q <= '0;
      end else if (rise) begin
        cnt_q <= rx_done_o ? '0 : cnt_q + 1'b1;
        sh_q  <= rx_done_o ? fill : sh_next;
      end
    end
  end

  // current bit sits at the outgoing end of the shifter
  assign miso_oe_o = active_o;
  assign miso_o    = active_o & (lsb_first_i ? sh_q[0] : sh_q[DATA_W-1]);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_slave_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              load_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              active_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              overrun_o,
  output logic              lsb_first_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] tx_hold_q, rx_hold_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              tx_empty_q, rx_full_q, ovr_q;
  logic              wr_data, rd_data, wr_stat, wr_ctrl, ovr_set;
  logic [STAT_W-1:0] stat;

  assign wr_data = wr_en_i & (addr_i == REG_DATA);
  assign wr_stat = wr_en_i & (addr_i == REG_STAT);
  assign wr_ctrl = wr_en_i & (addr_i == REG_CTRL);
  assign rd_data = rd_en_i & (addr_i == REG_DATA);
  assign ovr_set = rx_done_i & rx_full_q & ~rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_hold_q  <= '0;
      rx_hold_q  <= '0;
      ctrl_q     <= '0;
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (wr_data) tx_hold_q <= wr_data_i;
      // host write wins over a same-cycle load
      if (wr_data)     tx_empty_q <= 1'b0;
      else if (load_i) tx_empty_q <= 1'b1;

      if (rx_done_i) begin
        rx_hold_q <= rx_byte_i;
        rx_full_q <= 1'b1;
      end else if (rd_data) begin
        rx_full_q <= 1'b0;
      end

      if (ovr_set)                           ovr_q <= 1'b1;
      else if (wr_stat && wr_data_i[STAT_OVR]) ovr_q <= 1'b0;

      if (wr_ctrl) ctrl_q <= wr_data_i[CTRL_W-1:0];
    end
  end

  assign stat = {3'b000, active_i, ovr_q, rx_full_q, tx_empty_q};

  always_comb begin
    unique case (addr_i)
      REG_DATA: rd_data_o = rx_hold_q;
      REG_STAT: rd_data_o = DATA_W'(stat);
      REG_CTRL: rd_data_o = DATA_W'(ctrl_q);
      default:  rd_data_o = '0;
    endcase
  end

  assign tx_byte_o   = tx_hold_q;
  assign tx_empty_o  = tx_empty_q;
  assign rx_full_o   = rx_full_q;
  assign overrun_o   = ovr_q;
  assign lsb_first_o = ctrl_q[CTRL_LSB];
  assign irq_o = (tx_empty_q & ctrl_q[CTRL_IE_TX]) |
                 (rx_full_q  & ctrl_q[CTRL_IE_RX]) |
                 (ovr_q      & ctrl_q[CTRL_IE_OVR]);
endmodule

// File: rtl/spi_slave_dbuf.sv
module spi_slave_dbuf
  import spi_slave_dbuf_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              mosi_i,
  input  logic              cs_ni,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [2:0]        pins_s;
  logic              load, rx_done, active, lsb_first;
  logic              tx_empty, rx_full, overrun;
  logic [DATA_W-1:0] rx_byte, tx_byte;

  spi_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, mosi_i, sclk_i}),
    .q_o   (pins_s)
  );

  spi_shift_core #(.DATA_W(DATA_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (pins_s[0]),
    .mosi_i     (pins_s[1]),
    .cs_ni      (pins_s[2]),
    .lsb_first_i(lsb_first),
    .tx_byte_i  (tx_byte),
    .tx_valid_i (~tx_empty),
    .load_o     (load),
    .rx_done_o  (rx_done),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .active_o   (active)
  );

  spi_host_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .load_i     (load),
    .rx_done_i  (rx_done),
    .rx_byte_i  (rx_byte),
    .active_i   (active),
    .tx_byte_o  (tx_byte),
    .tx_empty_o (tx_empty),
    .rx_full_o  (rx_full),
    .overrun_o  (overrun),
    .lsb_first_o(lsb_first),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/spi_slave_dbuf_chk.sv
module spi_slave_dbuf_chk #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic [1:0] addr_i,
  input logic       wr_en_i,
  input logic [2:0] wr_lo_i,
  input logic       rd_en_i,
  input logic       miso_o,
  input logic       miso_oe_o,
  input logic       irq_o,
  input logic       tx_empty,
  input logic       rx_full,
  input logic       overrun,
  input logic       rx_done,
  input logic       load
);
  logic [3:0] hi_cnt, lo_cnt;
  logic [2:0] ie_shadow;
  logic       wr_d, wr_s, wr_c, rd_d;

  assign wr_d = wr_en_i & (addr_i == 2'd0);
  assign wr_s = wr_en_i & (addr_i == 2'd1);
  assign wr_c = wr_en_i & (addr_i == 2'd2);
  assign rd_d = rd_en_i & (addr_i == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      ie_shadow <= '0;
    end else begin
      hi_cnt <= cs_ni  ? ((hi_cnt == 4'hf) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= !cs_ni ? ((lo_cnt == 4'hf) ? lo_cnt : lo_cnt + 1'b1) : '0;
      if (wr_c) ie_shadow <= wr_lo_i;
    end
  end

  AST_OE_OFF_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_cnt >= 4'(SYNC_STAGES)) |-> (!miso_oe_o && !miso_o)); // R9
  AST_OE_ON_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_cnt >= 4'(SYNC_STAGES)) |-> miso_oe_o); // R9
  AST_TXWR_CLEARS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_d |=> !tx_empty); // R2
  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wr_d) |=> tx_empty); // R3
  AST_DONE_SETS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done |=> rx_full); // R5
  AST_READ_CLEARS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_d && !rx_done) |=> !rx_full); // R5
  AST_OVR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_full && !rd_d) |=> overrun); // R7
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun && !(wr_s && wr_lo_i[2])) |=> overrun); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_shadow == 3'b000) |-> !irq_o); // R11
endmodule

bind spi_slave_dbuf spi_slave_dbuf_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .addr_i   (addr_i),
  .wr_en_i  (wr_en_i),
  .wr_lo_i  (wr_data_i[2:0]),
  .rd_en_i  (rd_en_i),
  .miso_o   (miso_o),
  .miso_oe_o(miso_oe_o),
  .irq_o    (irq_o),
  .tx_empty (tx_empty),
  .rx_full  (rx_full),
  .overrun  (overrun),
  .rx_done  (rx_done),
  .load     (load)
);

// File: tb/spi_slave_dbuf_bench.sv
module spi_slave_dbuf_bench;
  import spi_slave_dbuf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk, rst_n, sclk, mosi, cs_n, miso, miso_oe, wr_en, rd_en, irq;
  logic [1:0] addr;
  logic [7:0] wr_data, rd_data;

  spi_slave_dbuf u_spi_slave_dbuf (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cs_ni(cs_n),
    .miso_o(miso), .miso_oe_o(miso_oe), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model
  bit       m_tx_full = 0, m_rx_full = 0, m_ovr = 0, m_lsb = 0;
  logic [7:0] m_tx_val = '0, m_rx = '0, m_cur = '0;
  logic [2:0] m_ie = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] take_load();
    if (m_tx_full) begin
      m_tx_full = 0;
      return m_tx_val;
    end
    return 8'hff;
  endfunction

  function automatic logic [7:0] exp_stat(bit sel);
    return {4'b0, sel, m_ovr, m_rx_full, ~m_tx_full};
  endfunction

  function automatic logic exp_irq();
    return (~m_tx_full & m_ie[0]) | (m_rx_full & m_ie[1]) | (m_ovr & m_ie[2]);
  endfunction

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tx_write(logic [7:0] v);
    bus_wr(REG_DATA, v);
    m_tx_full = 1; m_tx_val = v;
  endtask

  task automatic set_ctrl(bit lsb, logic [2:0] ie);
    bus_wr(REG_CTRL, {4'b0, lsb, ie});
    m_lsb = lsb; m_ie = ie;
  endtask

  task automatic check_stat(string req, bit sel);
    logic [7:0] r;
    bus_rd(REG_STAT, r);
    chk(req, r, exp_stat(sel));
    chk({req, " irq"}, irq, exp_irq());
  endtask

  task automatic rx_read(string req);
    logic [7:0] r;
    bus_rd(REG_DATA, r);
    chk(req, r, m_rx);
    m_rx_full = 0;
  endtask

  task automatic sel_open();
    cs_n = 1'b0;
    repeat (8) @(negedge clk);
    m_cur = take_load();
  endtask

  task automatic sel_close();
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic shift_bits(logic [7:0] mo, int nbits, bit mid_wr, logic [7:0] mid_val,
                            output logic [7:0] mi);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      int p;
      p = m_lsb ? i : 7 - i;
      mosi = mo[p];
      if (mid_wr && i == 3) bus_wr(REG_DATA, mid_val);
      repeat (HALF) @(negedge clk);
      mi[p] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // one full byte: check outgoing byte, update model incl. next load
  task automatic byte_io(string req, logic [7:0] mo, bit mid_wr, logic [7:0] mid_val);
    logic [7:0] mi;
    shift_bits(mo, 8, mid_wr, mid_val, mi);
    chk(req, mi, m_cur);
    if (m_rx_full) m_ovr = 1;
    m_rx_full = 1; m_rx = mo;
    if (mid_wr) begin m_tx_full = 1; m_tx_val = mid_val; end
    m_cur = take_load();
  endtask

  initial begin
    logic [7:0] r, mi;
    void'($urandom(32'd1234));
    rst_n = 1'b0; sclk = 1'b0; mosi = 1'b0; cs_n = 1'b1;
    addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    chk("R1 oe", miso_oe, 1'b0);
    chk("R1 miso", miso, 1'b0);
    chk("R1 irq", irq, 1'b0);
    bus_rd(REG_CTRL, r); chk("R1 ctrl", r, 8'h00);
    check_stat("R1 stat", 0);

    // R2 preload, R3/R4 msb-first transfer, R5 receive
    tx_write(8'ha5);
    check_stat("R2 stat", 0);
    sel_open();
    chk("R9 oe selected", miso_oe, 1'b1);
    check_stat("R3 stat during select", 1);
    byte_io("R4 msb-first tx", 8'h3c, 0, '0);
    sel_close();
    chk("R9 oe deselected", miso_oe, 1'b0);
    chk("R9 miso deselected", miso, 1'b0);
    check_stat("R5 rx full", 0);
    rx_read("R5 rx data");
    check_stat("R5 rx cleared", 0);

    // R3 fill with 0xFF when nothing preloaded
    sel_open();
    byte_io("R3 fill 0xff", 8'h5a, 0, '0);
    sel_close();
    rx_read("R3 rx after fill");

    // R6 back-to-back with mid-byte preload
    tx_write(8'h11);
    sel_open();
    byte_io("R6 first", 8'hc3, 1, 8'h22);
    byte_io("R6 second", 8'h96, 0, '0);
    sel_close();
    check_stat("R7 overrun after two", 0);
    rx_read("R7 newest kept");
    check_stat("R7 sticky", 0);
    bus_wr(REG_STAT, 8'h04); m_ovr = 0;
    check_stat("R7 cleared", 0);

    // R8 partial byte discarded
    sel_open();
    shift_bits(8'hf0, 5, 0, '0, mi);
    sel_close();
    check_stat("R8 no rx", 0);
    sel_open();
    byte_io("R8 fresh count tx", 8'h81, 0, '0);
    sel_close();
    rx_read("R8 fresh count rx");

    // R10 lsb-first
    set_ctrl(1, 3'b000);
    tx_write(8'h01);
    sel_open();
    byte_io("R10 lsb-first tx", 8'h80, 0, '0);
    sel_close();
    rx_read("R10 lsb-first rx");

    // R11 interrupt enables
    set_ctrl(0, 3'b010);
    sel_open(); byte_io("R11 xfer", 8'h42, 0, '0); sel_close();
    chk("R11 rx irq", irq, 1'b1);
    set_ctrl(0, 3'b000);
    chk("R11 masked", irq, 1'b0);
    set_ctrl(0, 3'b001);
    chk("R11 tx irq", irq, 1'b1);
    rx_read("R11 drain");

    // random mix
    for (int s = 0; s < 60; s++) begin
      int n;
      set_ctrl(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)));
      if ($urandom_range(0, 1) == 1 && !m_tx_full) tx_write(8'($urandom));
      n = $urandom_range(1, 3);
      sel_open();
      for (int b = 0; b < n; b++) begin
        bit mw;
        mw = (b < n - 1) && ($urandom_range(0, 1) == 1);
        byte_io("R6 random tx", 8'($urandom), mw, 8'($urandom));
      end
      sel_close();
      check_stat("R7 random stat", 0);
      if ($urandom_range(0, 1) == 1) rx_read("R5 random rx");
      if (m_ovr && $urandom_range(0, 1) == 1) begin
        bus_wr(REG_STAT, 8'h04); m_ovr = 0;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule